// File: doc/BRIEF.md
# Buffered Peripheral Write Bridge

This block sits between a system-side producer and a slow output peripheral. Words offered on a valid/ready write port go into a small first-in, first-out buffer. A handshake engine then moves them to the peripheral one at a time, so the producer can run ahead of the peripheral until the buffer fills.

Each word needs two acknowledgements from the peripheral. The engine first raises a request-to-send line and waits for a grant. Only after the grant does it drive the word with a strobe, and it holds both steady until the peripheral confirms receipt. The buffer entry is released only on that confirmation, so a word cannot be lost while a transfer is in progress.

A synchronous, active-high reset empties the buffer and returns every peripheral-side output to zero.

Top module: `periph_wr_bridge`

## Requirements
- R1: When the engine is idle and the buffer holds at least one word, `per_req` goes high at the next rising edge. A word accepted on edge k therefore shows `per_req` high after edge k+1 and not after edge k.
- R2: `per_req` stays high until `per_grant` is sampled high, and it is low from the following cycle on.
- R3: `per_strobe` rises in the cycle after the grant is sampled, carrying the oldest buffered word on `per_data`. `per_strobe` is never high while `per_req` is high.
- R4: `per_data` and `per_strobe` hold steady until `per_done` is sampled high. In the cycle after that, both are low (`per_data` reads zero).
- R5: A word leaves the buffer only when `per_done` is accepted. Words reach the peripheral in the order they were written, with none lost and none repeated.
- R6: `wr_ready` is low while the buffer holds DEPTH words (8 by default). A `wr_valid` presented while `wr_ready` is low is not accepted.
- R7: A `per_grant` outside the request phase and a `per_done` outside the waiting-for-receipt phase are ignored. This covers `per_done` during the first strobe cycle.
- R8: `busy` is high whenever the engine is not idle or the buffer is non-empty, and low otherwise.
- R9: Synchronous reset empties the buffer and idles the engine. After reset, `per_req`, `per_strobe` and `per_data` are low, `busy` is low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | System side offers a word |
| wr_data | input | DATA_W | Word offered by the system side |
| wr_ready | output | 1 | Buffer can take a word |
| per_req | output | 1 | Request permission to send |
| per_grant | input | 1 | Peripheral grants permission |
| per_data | output | DATA_W | Word driven to the peripheral |
| per_strobe | output | 1 | `per_data` is valid |
| per_done | input | 1 | Peripheral confirms receipt |
| busy | output | 1 | Transfer in progress or words pending |

## Verification
Some rules are checked by the assertions on every cycle. These are the request held until a grant, strobe and data held until receipt, request and strobe never overlapping, no push into a full buffer, no release from an empty one, and busy covering a full buffer.

Other behaviour can only be shown by the bench's scenarios. These cover:
- the exact cycle the request rises;
- delivery order under slow and fast peripheral timing;
- refusal of writes while the buffer is full;
- stray acknowledgements having no effect;
- what a mid-transfer reset discards.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_REQ  = 2'd1,
      HS_SEND = 2'd2,
      HS_WAIT = 2'd3
   } hs_state_t;

   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo
   import pwb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full
);
   localparam int unsigned AW   = ptr_width(DEPTH);
   localparam int unsigned CW   = $clog2(DEPTH + 1);
   localparam bit          POW2 = ((1 << AW) == DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]     count;

   if (DEPTH < 2) begin : g_bad_depth
      $error("pwb_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pwb_fifo: DATA_W must be at least 1");
   end

   // pointer wrap: free on a power of two, explicit compare otherwise
   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      push |-> !full) else $error("push into full buffer"); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty) else $error("pop from empty buffer"); // R5
endmodule

// File: rtl/pwb_handshake.sv
module pwb_handshake
   import pwb_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              head_valid,
   input  logic [DATA_W-1:0] head_data,
   output logic              pop,
   output logic              req_o,
   input  logic              grant_i,
   output logic [DATA_W-1:0] data_o,
   output logic              strobe_o,
   input  logic              done_i,
   output logic              active_o
);
   hs_state_t         state, state_nxt;
   logic [DATA_W-1:0] hold_q;

   always_comb begin
      state_nxt = state;
      unique case (state)
         HS_IDLE: if (head_valid) state_nxt = HS_REQ;
         HS_REQ:  if (grant_i)    state_nxt = HS_SEND;
         HS_SEND:                 state_nxt = HS_WAIT;
         HS_WAIT: if (done_i)     state_nxt = HS_IDLE;
         default:                 state_nxt = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= HS_IDLE;
         hold_q <= '0;
      end else begin
         state <= state_nxt;
         if (state == HS_REQ && grant_i)
            hold_q <= head_data;
         else if (state == HS_WAIT && done_i)
            hold_q <= '0;
      end
   end

   assign pop      = (state == HS_WAIT) && done_i;
   assign req_o    = (state == HS_REQ);
   assign strobe_o = (state == HS_SEND) || (state == HS_WAIT);
   assign data_o   = hold_q;
   assign active_o = (state != HS_IDLE);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (req_o && !grant_i) |=> req_o) else $error("request dropped early"); // R2
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
      (req_o && grant_i) |=> (!req_o && strobe_o)) else $error("no strobe after grant"); // R3
   AST_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
      (strobe_o && !done_i) |=> (strobe_o && $stable(data_o))) else $error("data moved"); // R4
   AST_REQ_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(req_o && strobe_o)) else $error("request and strobe overlap"); // R3
endmodule

// File: rtl/periph_wr_bridge.sv
module periph_wr_bridge
   import pwb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              per_req,
   input  logic              per_grant,
   output logic [DATA_W-1:0] per_data,
   output logic              per_strobe,
   input  logic              per_done,
   output logic              busy
);
   logic              push, pop, empty, full, active;
   logic [DATA_W-1:0] head;

   assign wr_ready = !full;
   assign push     = wr_valid && !full;

   pwb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .push(push), .push_data(wr_data),
      .pop(pop), .head(head),
      .empty(empty), .full(full)
   );

   pwb_handshake #(.DATA_W(DATA_W)) u_hs (
      .clk(clk), .rst(rst),
      .head_valid(!empty), .head_data(head), .pop(pop),
      .req_o(per_req), .grant_i(per_grant),
      .data_o(per_data), .strobe_o(per_strobe),
      .done_i(per_done), .active_o(active)
   );

   assign busy = active || !empty;

   AST_REQ_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
      per_req |-> !empty) else $error("request with empty buffer"); // R1
   AST_BUSY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
      !wr_ready |-> busy) else $error("full but not busy"); // R8
   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
      per_strobe |-> busy) else $error("strobe while not busy"); // R8
endmodule

// File: tb/periph_wr_bridge_test.sv
module periph_wr_bridge_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int DEPTH = 8;

   logic clk = 0, rst = 1;
   logic wr_valid = 0;
   logic [DW-1:0] wr_data = '0;
   logic wr_ready, per_req, per_strobe, busy;
   logic [DW-1:0] per_data;
   logic m_grant = 0, t_grant = 0, m_done = 0, t_done = 0;

   int checks = 0, fails = 0, cycles = 0;
   logic [DW-1:0] exp_q [64];
   int exp_wr = 0, exp_rd = 0;
   int pen = 0, gdly = 0, ddly = 0;
   int ps = 0, cnt = 0;
   logic [DW-1:0] lat;

   always #(CLK_PERIOD/2) clk = ~clk;

   periph_wr_bridge #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .per_req(per_req), .per_grant(m_grant | t_grant), .per_data(per_data),
      .per_strobe(per_strobe), .per_done(m_done | t_done), .busy(busy));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural peripheral with programmable delays
   always @(negedge clk) begin
      if (pen == 0) begin
         ps = 0; m_grant = 0; m_done = 0;
      end else begin
         case (ps)
            0: if (per_req) begin cnt = 0; ps = 1; end
            1: begin
               chk("R2 req held while waiting", 32'(per_req), 1);
               if (cnt >= gdly) begin m_grant = 1; ps = 2; end else cnt++;
            end
            2: if (!per_req) begin
               m_grant = 0; cnt = 0; ps = 3; lat = per_data;
               chk("R3 strobe after grant", 32'(per_strobe), 1);
            end
            3: begin
               chk("R4 strobe held", 32'(per_strobe), 1);
               chk("R4 data held", 32'(per_data), 32'(lat));
               if (cnt >= ddly) begin
                  if (exp_rd < exp_wr)
                     chk("R5 word order", 32'(per_data), 32'(exp_q[exp_rd % 64]));
                  else
                     chk("R5 unexpected extra word", 1, 0);
                  m_done = 1; ps = 4;
               end else cnt++;
            end
            4: if (!per_strobe) begin
               chk("R4 data cleared after done", 32'(per_data), 0);
               m_done = 0; exp_rd++; ps = 0;
            end
            default: ps = 0;
         endcase
      end
   end

   task automatic write_word(input logic [DW-1:0] d);
      logic acc;
      @(negedge clk);
      wr_valid = 1; wr_data = d;
      forever begin
         acc = wr_ready;
         @(negedge clk);
         if (acc) break;
      end
      exp_q[exp_wr % 64] = d; exp_wr++;
      wr_valid = 0;
   endtask

   task automatic drain(input string req);
      int t = 0;
      while ((exp_rd != exp_wr || busy) && t < 5000) begin @(negedge clk); t++; end
      chk({req, " all words delivered"}, 32'(exp_rd), 32'(exp_wr));
      chk("R8 busy low when drained", 32'(busy), 0);
   endtask

   task automatic t_reset_state();
      chk("R9 req low after reset", 32'(per_req), 0);
      chk("R9 strobe low after reset", 32'(per_strobe), 0);
      chk("R9 data zero after reset", 32'(per_data), 0);
      chk("R9 busy low after reset", 32'(busy), 0);
      chk("R9 ready high after reset", 32'(wr_ready), 1);
   endtask

   task automatic t_req_timing();
      pen = 0;
      write_word(8'hA5);
      chk("R1 req not yet high", 32'(per_req), 0);
      chk("R8 busy with pending word", 32'(busy), 1);
      @(negedge clk);
      chk("R1 req high next cycle", 32'(per_req), 1);
      chk("R3 no strobe before grant", 32'(per_strobe), 0);
      pen = 1; gdly = 0; ddly = 0;
      drain("R1");
   endtask

   task automatic t_stream(input int g, input int d, input int n, input logic [DW-1:0] seed);
      pen = 1; gdly = g; ddly = d;
      for (int i = 0; i < n; i++) write_word(seed + DW'(i * 37));
      drain("R5");
   endtask

   task automatic t_full();
      pen = 0;
      for (int i = 0; i < DEPTH; i++) write_word(8'h10 + DW'(i));
      chk("R6 ready low when full", 32'(wr_ready), 0);
      chk("R8 busy when full", 32'(busy), 1);
      wr_valid = 1; wr_data = 8'hEE;
      repeat (3) @(negedge clk);
      wr_valid = 0;
      chk("R6 still full, extra word refused", 32'(wr_ready), 0);
      pen = 1; gdly = 2; ddly = 1;
      drain("R6");
   endtask

   task automatic t_stray();
      pen = 0;
      t_grant = 1; @(negedge clk); t_grant = 0; @(negedge clk);
      chk("R7 grant in idle ignored (req)", 32'(per_req), 0);
      chk("R7 grant in idle ignored (strobe)", 32'(per_strobe), 0);
      t_done = 1; @(negedge clk); t_done = 0;
      chk("R7 done in idle ignored", 32'(busy), 0);
      write_word(8'h3C);
      @(negedge clk);
      t_done = 1; @(negedge clk); t_done = 0;
      chk("R7 done during request ignored", 32'(per_req), 1);
      chk("R7 no strobe from stray done", 32'(per_strobe), 0);
      t_grant = 1; @(negedge clk); t_grant = 0;
      chk("R3 strobe in first cycle", 32'(per_strobe), 1);
      chk("R3 head word on data", 32'(per_data), 32'h3C);
      t_done = 1; @(negedge clk); t_done = 0;
      chk("R7 done in first strobe cycle ignored", 32'(per_strobe), 1);
      t_grant = 1; @(negedge clk); t_grant = 0;
      chk("R7 grant while waiting ignored", 32'(per_data), 32'h3C);
      t_done = 1; @(negedge clk); t_done = 0;
      chk("R4 strobe low after done", 32'(per_strobe), 0);
      chk("R5 word released once", 32'(busy), 0);
      exp_rd++;
   endtask

   task automatic t_mid_reset();
      pen = 0;
      write_word(8'h01); write_word(8'h02); write_word(8'h03);
      @(negedge clk);
      rst = 1; @(negedge clk); rst = 0;
      exp_rd = exp_wr;
      t_reset_state();
      write_word(8'h77); write_word(8'h88);
      pen = 1; gdly = 1; ddly = 3;
      drain("R9");
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected<=150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      t_reset_state();
      t_req_timing();
      t_stream(0, 0, 12, 8'h21);
      t_stream(5, 7, 12, 8'h40);
      t_stream(3, 0, 6, 8'h90);
      t_full();
      t_stray();
      t_mid_reset();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule